// File: doc/BRIEF.md
# Per-Core Local Exclusive Monitor

This block sits next to one core's load/store unit and keeps that core's exclusive reservation. It sees every memory request the core issues: ordinary loads and stores, and the load-exclusive / store-exclusive pair used to build atomic read-modify-write sequences. Each request carries an address and a size in bytes. A load-exclusive records a reservation made of the address and the size. Any ordinary access in between removes it. A store-exclusive is compared against the reservation.

For each store-exclusive the block gives a local verdict. It combines that verdict with the global monitor's answer, which arrives alongside the request, to decide whether memory may be written. It also produces the status bit that goes to the destination register: 0 when the store took effect and 1 when it did not. All responses are registered and appear exactly one cycle after the request strobe.

Top module: `excl_local_monitor`

## Requirements
- R1: After a synchronous active-high reset the reservation is empty (`excl_held` = 0, tag address 0, tag size None), and every response output is 0.
- R2: `req_bytes` encodes the access size: 0 gives None, 1 gives Byte, 2 gives HalfWord and 4 gives Word. Any other value is illegal for an exclusive access. Such an access raises `rsp_access_err` and leaves the reservation untouched.
- R3: A legal, aligned load-exclusive (`req_op` = 2'b10) sets the reservation and records the exact address and the size, replacing any earlier reservation.
- R4: A plain load (`req_op` = 2'b00) or plain store (2'b01) empties a held reservation. Plain accesses never raise an error and never report a pass, a commit or a status of 1.
- R5: A store-exclusive (`req_op` = 2'b11) made while a reservation is held passes locally only if its full, unmasked address and its size both equal the recorded ones. The reservation is emptied whether it passes or fails.
- R6: A store-exclusive made while no reservation is held fails locally, and the state stays empty.
- R7: `rsp_commit` is 1 only when the local check passes and `global_ok` is 1 with the request. `rsp_status` for a store-exclusive is 0 when it commits and 1 otherwise.
- R8: An exclusive access whose address is not a multiple of its size raises `rsp_access_err`, changes no state, and (for a store-exclusive) gives status 1 with no commit.
- R9: `rsp_valid` and all `rsp_*` outputs describe the request strobed on the previous clock edge. `rsp_valid` is 0 in a cycle after no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 00 load, 01 store, 10 load-exclusive, 11 store-exclusive |
| req_addr | input | ADDR_W | Byte address of the access |
| req_bytes | input | 3 | Access size in bytes (0, 1, 2 or 4 legal) |
| global_ok | input | 1 | Global monitor's verdict for this request |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_local_pass | output | 1 | Store-exclusive passed the local check |
| rsp_commit | output | 1 | Memory write may proceed |
| rsp_status | output | 1 | Status for the destination register (0 success, 1 failure) |
| rsp_access_err | output | 1 | Exclusive access misaligned or of illegal size |
| excl_held | output | 1 | A reservation is currently held |

## Verification
The hardest situation to reach is a store-exclusive whose address matches the reservation but whose size differs, or which passes locally while the global monitor refuses. Both need a load-exclusive to be followed by a store-exclusive with no ordinary access in between. The stimulus covers these with directed sequences for each case. It then runs a long random phase over a handful of nearby addresses and a size set that is weighted toward legal values, so that matches, near-misses and misaligned attempts all occur often. A behavioural model in the bench is compared against the outputs on every cycle.

// File: rtl/exmon_pkg.sv
package exmon_pkg;

    typedef enum logic [1:0] {
        OP_LD  = 2'b00,
        OP_ST  = 2'b01,
        OP_LDX = 2'b10,
        OP_STX = 2'b11
    } exm_op_e;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_BYTE = 2'd1,
        SZ_HALF = 2'd2,
        SZ_WORD = 2'd3
    } exm_size_e;

    typedef struct packed {
        logic      legal;
        exm_size_e size;
    } size_dec_t;

    // Classified request as seen by the reservation and verdict stages
    typedef struct packed {
        logic      vld;
        logic      plain;
        logic      ldx;
        logic      stx;
        logic      bad;
        exm_size_e size;
    } req_cls_t;

    localparam int BYTES_W = 3;

    function automatic size_dec_t decode_bytes(input logic [BYTES_W-1:0] b);
        size_dec_t d;
        d.legal = 1'b1;
        case (b)
            3'd0:    d.size = SZ_NONE;
            3'd1:    d.size = SZ_BYTE;
            3'd2:    d.size = SZ_HALF;
            3'd4:    d.size = SZ_WORD;
            default: begin
                d.size  = SZ_NONE;
                d.legal = 1'b0;
            end
        endcase
        return d;
    endfunction

    function automatic logic addr_aligned(input exm_size_e s, input logic [1:0] lo);
        logic ok;
        case (s)
            SZ_HALF: ok = (lo[0] == 1'b0);
            SZ_WORD: ok = (lo == 2'b00);
            default: ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/exmon_classify.sv
module exmon_classify
    import exmon_pkg::*;
(
    input  logic               req_valid,
    input  logic [1:0]         req_op,
    input  logic [1:0]         addr_lo,
    input  logic [BYTES_W-1:0] req_bytes,
    output req_cls_t           cls
);

    size_dec_t sdec;
    exm_op_e   op;
    logic      excl;

    always_comb begin
        op    = exm_op_e'(req_op);
        sdec  = decode_bytes(req_bytes);
        excl  = (op == OP_LDX) || (op == OP_STX);

        cls.vld   = req_valid;
        cls.plain = req_valid && !excl;
        cls.ldx   = req_valid && (op == OP_LDX);
        cls.stx   = req_valid && (op == OP_STX);
        cls.size  = sdec.size;
        // Illegal size or misalignment only matters for exclusive accesses
        cls.bad   = req_valid && excl &&
                    (!sdec.legal || !addr_aligned(sdec.size, addr_lo));
    end

endmodule

// File: rtl/exmon_reservation.sv
module exmon_reservation
    import exmon_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  req_cls_t          cls,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              excl_q,
    output logic              tag_match
);

    logic [ADDR_W-1:0] tag_addr_q;
    exm_size_e         tag_size_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            excl_q     <= 1'b0;
            tag_addr_q <= '0;
            tag_size_q <= SZ_NONE;
        end else if (cls.ldx && !cls.bad) begin
            excl_q     <= 1'b1;
            tag_addr_q <= req_addr;
            tag_size_q <= cls.size;
        end else if (excl_q && (cls.plain || (cls.stx && !cls.bad))) begin
            excl_q     <= 1'b0;
            tag_addr_q <= '0;
            tag_size_q <= SZ_NONE;
        end
    end

    // Exact comparison: no address masking
    always_comb begin
        tag_match = excl_q && (req_addr == tag_addr_q) && (cls.size == tag_size_q);
    end

    AST_PLAIN_DROPS: assert property (@(posedge clk) disable iff (rst)
        cls.plain |=> !excl_q); // R4

    AST_LDX_TAGS: assert property (@(posedge clk) disable iff (rst)
        (cls.ldx && !cls.bad) |=> (excl_q && tag_addr_q == $past(req_addr))); // R3

    AST_BAD_KEEPS: assert property (@(posedge clk) disable iff (rst)
        cls.bad |=> ($stable(excl_q) && $stable(tag_addr_q))); // R8

    AST_STX_OPENS: assert property (@(posedge clk) disable iff (rst)
        (cls.stx && !cls.bad) |=> !excl_q); // R5

endmodule

// File: rtl/exmon_verdict.sv
module exmon_verdict
    import exmon_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  req_cls_t cls,
    input  logic     tag_match,
    input  logic     global_ok,
    output logic     rsp_valid,
    output logic     rsp_local_pass,
    output logic     rsp_commit,
    output logic     rsp_status,
    output logic     rsp_access_err
);

    logic pass_d;
    logic commit_d;

    always_comb begin
        pass_d   = cls.stx && !cls.bad && tag_match;
        commit_d = pass_d && global_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_local_pass <= 1'b0;
            rsp_commit     <= 1'b0;
            rsp_status     <= 1'b0;
            rsp_access_err <= 1'b0;
        end else begin
            rsp_valid      <= cls.vld;
            rsp_local_pass <= pass_d;
            rsp_commit     <= commit_d;
            rsp_status     <= cls.stx && !commit_d;
            rsp_access_err <= cls.bad;
        end
    end

    AST_RSP_TIMING: assert property (@(posedge clk) disable iff (rst)
        cls.vld |=> rsp_valid); // R9

    AST_COMMIT_NEEDS_PASS: assert property (@(posedge clk) disable iff (rst)
        rsp_commit |-> (rsp_local_pass && rsp_valid)); // R7

    AST_COMMIT_STATUS: assert property (@(posedge clk) disable iff (rst)
        rsp_commit |-> !rsp_status); // R7

    AST_ERR_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        rsp_access_err |-> !rsp_commit); // R8

endmodule

// File: rtl/excl_local_monitor.sv
module excl_local_monitor
    import exmon_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_bytes,
    input  logic              global_ok,
    output logic              rsp_valid,
    output logic              rsp_local_pass,
    output logic              rsp_commit,
    output logic              rsp_status,
    output logic              rsp_access_err,
    output logic              excl_held
);

    req_cls_t cls;
    logic     tag_match;

    exmon_classify u_classify (
        .req_valid (req_valid),
        .req_op    (req_op),
        .addr_lo   (req_addr[1:0]),
        .req_bytes (req_bytes),
        .cls       (cls)
    );

    exmon_reservation #(.ADDR_W(ADDR_W)) u_resv (
        .clk       (clk),
        .rst       (rst),
        .cls       (cls),
        .req_addr  (req_addr),
        .excl_q    (excl_held),
        .tag_match (tag_match)
    );

    exmon_verdict u_verdict (
        .clk            (clk),
        .rst            (rst),
        .cls            (cls),
        .tag_match      (tag_match),
        .global_ok      (global_ok),
        .rsp_valid      (rsp_valid),
        .rsp_local_pass (rsp_local_pass),
        .rsp_commit     (rsp_commit),
        .rsp_status     (rsp_status),
        .rsp_access_err (rsp_access_err)
    );

    AST_OPEN_STX_FAILS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b11 && !excl_held) |=> (!rsp_local_pass && !excl_held)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R9

endmodule

// File: tb/excl_local_monitor_test.sv
module excl_local_monitor_test;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic [1:0]    req_op;
    logic [AW-1:0] req_addr;
    logic [2:0]    req_bytes;
    logic          global_ok;
    logic          rsp_valid, rsp_local_pass, rsp_commit, rsp_status, rsp_access_err, excl_held;

    int checks = 0;
    int errors = 0;

    // Reference model state
    bit            m_excl = 0;
    logic [AW-1:0] m_addr = '0;
    int            m_bytes = 0;

    always #2 clk = ~clk;

    excl_local_monitor #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_bytes(req_bytes), .global_ok(global_ok),
        .rsp_valid(rsp_valid), .rsp_local_pass(rsp_local_pass),
        .rsp_commit(rsp_commit), .rsp_status(rsp_status),
        .rsp_access_err(rsp_access_err), .excl_held(excl_held)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cmp_all(input string tag, input bit v, input bit p, input bit c,
                           input bit s, input bit e);
        chk(tag, "rsp_valid", rsp_valid, v);
        chk(tag, "rsp_local_pass", rsp_local_pass, p);
        chk(tag, "rsp_commit", rsp_commit, c);
        chk(tag, "rsp_status", rsp_status, s);
        chk(tag, "rsp_access_err", rsp_access_err, e);
        chk(tag, "excl_held", excl_held, m_excl);
    endtask

    // One request, model update, compare one cycle later
    task automatic req(input int op, input logic [AW-1:0] a, input int nb,
                       input bit gok, input string tag);
        bit legal, aligned, bad, p, c, s, e;
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = 2'(op);
        req_addr  = a;
        req_bytes = 3'(nb);
        global_ok = gok;
        legal   = (nb == 0) || (nb == 1) || (nb == 2) || (nb == 4);
        aligned = !legal || (nb == 0) || ((a % nb) == 0);
        bad     = (op >= 2) && !(legal && aligned);
        p = 0; c = 0; s = 0; e = 0;
        if (op < 2) begin
            m_excl = 0;
        end else if (op == 2) begin
            if (bad) e = 1;
            else begin m_excl = 1; m_addr = a; m_bytes = nb; end
        end else begin
            if (bad) begin e = 1; s = 1; end
            else if (m_excl) begin
                p = (a == m_addr) && (nb == m_bytes);
                c = p && gok;
                s = !c;
                m_excl = 0;
            end else s = 1;
        end
        @(posedge clk);
        #1;
        cmp_all(tag, 1, p, c, s, e);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        req_valid = 1'b0;
        req_op    = 2'b11;
        req_addr  = 32'h104;
        req_bytes = 3'd4;
        global_ok = 1'b1;
        @(posedge clk);
        #1;
        cmp_all(tag, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] pool [5];
        int            szs [6];
        pool[0] = 32'h100; pool[1] = 32'h101; pool[2] = 32'h102;
        pool[3] = 32'h104; pool[4] = 32'h200;
        szs[0] = 0; szs[1] = 1; szs[2] = 2; szs[3] = 4; szs[4] = 4; szs[5] = 3;

        rst = 1'b1; req_valid = 0; req_op = 0; req_addr = 0; req_bytes = 0; global_ok = 0;
        repeat (3) @(posedge clk);
        #1;
        cmp_all("R1", 0, 0, 0, 0, 0);
        @(negedge clk);
        rst = 1'b0;

        // R6: store-exclusive with nothing reserved, even at tag 0 / size None
        req(3, 32'h0, 0, 1, "R6");
        req(3, 32'h104, 4, 1, "R6");
        idle("R9");
        // R3/R5/R7: clean success
        req(2, 32'h104, 4, 1, "R3");
        req(3, 32'h104, 4, 1, "R7");
        // R5: size mismatch at the same address
        req(2, 32'h104, 4, 1, "R3");
        req(3, 32'h104, 2, 1, "R5");
        req(3, 32'h104, 4, 1, "R6");
        // R5: address mismatch
        req(2, 32'h100, 2, 1, "R3");
        req(3, 32'h102, 2, 1, "R5");
        // R7: local pass but global refuses
        req(2, 32'h200, 1, 1, "R3");
        req(3, 32'h200, 1, 0, "R7");
        // R4: plain load and plain store break reservation
        req(2, 32'h104, 4, 1, "R3");
        req(0, 32'h300, 4, 1, "R4");
        req(3, 32'h104, 4, 1, "R4");
        req(2, 32'h104, 4, 1, "R3");
        req(1, 32'h101, 3, 1, "R4");
        req(3, 32'h104, 4, 1, "R4");
        // R2: illegal size keeps reservation
        req(2, 32'h100, 4, 1, "R3");
        req(2, 32'h100, 3, 1, "R2");
        req(3, 32'h100, 5, 1, "R2");
        req(3, 32'h100, 4, 1, "R2");
        // R8: misaligned exclusives
        req(2, 32'h102, 2, 1, "R3");
        req(2, 32'h102, 4, 1, "R8");
        req(3, 32'h101, 2, 1, "R8");
        req(3, 32'h102, 2, 1, "R8");
        // R3: new load-exclusive replaces old tag
        req(2, 32'h100, 1, 1, "R3");
        req(2, 32'h101, 1, 1, "R3");
        req(3, 32'h100, 1, 1, "R3");
        idle("R9");

        // Random phase against the model
        for (int i = 0; i < 3000; i++) begin
            int op = $urandom_range(0, 9);
            op = (op < 2) ? op : (op < 6 ? 2 : 3);
            if (op == 0 && $urandom_range(0, 1) == 1) op = 1;
            if ($urandom_range(0, 15) == 0) idle("R9");
            else req(op, pool[$urandom_range(0, 4)], szs[$urandom_range(0, 5)],
                     1'($urandom_range(0, 3) != 0), "R5");
        end

        // Reset mid-reservation returns to the empty state
        req(2, 32'h104, 4, 1, "R3");
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0;
        m_excl = 0;
        @(posedge clk);
        #1;
        cmp_all("R1", 0, 0, 0, 0, 0);
        @(negedge clk);
        rst = 1'b0;
        req(3, 32'h104, 4, 1, "R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule